// File: doc/BRIEF.md
# Bit Test, Modify and Branch Unit

This block carries out the single-bit and masked-bit instructions of an 8-bit processor core. The core hands it an opcode, the accumulator, the index register and the one or two operand bytes that follow the opcode. The unit then runs its own short sequence against a byte-wide memory port. It reads the target byte, works out the new value or the test result, writes the byte back when the instruction asks for it, and raises `done` for one cycle with the results.

There are five instruction groups. One clears or sets a single bit of a zero-page byte. One branches on the state of a single zero-page bit. One sets memory bits under an accumulator mask and reports whether the mask overlapped. One clears memory bits in the same way. The last is the bit-test instruction in immediate, zero-page, absolute and indexed forms. For the branch group the unit gives a taken flag and the offset, sign-extended, which the core adds to the address of the next instruction. The core also gets a flag write-enable for Z and one for the N/V pair, so it can update its status register, and the number of processor cycles the instruction costs. The program counter and the general addressing modes of other instructions stay in the core.

Top module: `bitop_unit`

## Requirements
- R1: After reset, and whenever `busy` is low, `done`, `mem_rd` and `mem_wr` are low, and `z_we`, `nv_we` and `br_taken` are low.
- R2: An opcode whose bits [3:0] are 4'b0111 reads the zero-page byte at address {8'h00, op_lo}. It writes back that byte with bit opcode[6:4] set when opcode[7] is 1, or cleared when opcode[7] is 0, to the same address. It writes no flag and reports 5 cycles.
- R3: An opcode whose bits [3:0] are 4'b1111 reads the zero-page byte at {8'h00, op_lo}. It sets `br_taken` when bit opcode[6:4] of that byte equals opcode[7], and performs no memory write and no flag write.
- R4: For a taken bit branch, `br_offset` is op_hi sign-extended to OFF_W bits and `cycles` is 3. For a branch not taken, `br_offset` is zero and `cycles` is 2.
- R5: Opcode 8'h04 (address {8'h00, op_lo}) and 8'h0C (address {op_hi, op_lo}) read the byte m. They raise `z_we` with Z = ((m AND acc) == 0), computed from the byte as read, and write (m OR acc) back.
- R6: Opcode 8'h14 (zero page) and 8'h1C (absolute) do the same with the write value (m AND NOT acc).
- R7: The set-bits and clear-bits opcodes report 3 cycles in zero-page form and 4 in absolute form, and never raise `nv_we`.
- R8: Opcode 8'h89 uses op_lo as its operand without any memory access. It raises `z_we` with Z = ((op_lo AND acc) == 0), leaves `nv_we` low and reports 2 cycles.
- R9: Opcodes 8'h24 (address {8'h00, op_lo}, 3 cycles), 8'h2C ({op_hi, op_lo}, 4 cycles), 8'h34 ({8'h00, op_lo + x_idx} wrapping inside page zero, 4 cycles) and 8'h3C ({op_hi, op_lo} + x_idx wrapping at 16 bits, 4 cycles) read m. They raise `z_we` with Z = ((m AND acc) == 0), and raise `nv_we` with N = m[7] and V = m[6].
- R10: Take the clock edge that samples `start` while idle as edge 0. The read is issued in the cycle after edge 0, `mem_rdata` is taken one cycle later, a write (if any) follows in the next cycle, and `done` is high for the one cycle after the last access. An operation with no memory access raises `done` in the cycle after edge 0. `start` is ignored while `busy` is high, and `busy` is low in the cycle after `done`.
- R11: Any other opcode raises `done` in the cycle after edge 0. It makes no memory access, writes no flag, does not branch and reports 0 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction; sampled only while idle |
| opcode | input | 8 | Instruction opcode |
| acc | input | 8 | Accumulator value |
| x_idx | input | 8 | Index register for the indexed bit-test forms |
| op_lo | input | 8 | First operand byte (address low, zero-page address or immediate) |
| op_hi | input | 8 | Second operand byte (address high or branch offset) |
| mem_addr | output | ADDR_W | Memory address, zero when no access |
| mem_rd | output | 1 | Read request; data returns one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data, zero when not writing |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse; result outputs valid |
| z_we | output | 1 | Write Z with `z_val` |
| z_val | output | 1 | New zero flag |
| nv_we | output | 1 | Write N and V with `n_val` and `v_val` |
| n_val | output | 1 | New negative flag |
| v_val | output | 1 | New overflow flag |
| br_taken | output | 1 | Bit branch is taken |
| br_offset | output | OFF_W | Sign-extended branch offset, zero when not taken |
| cycles | output | CYC_W | Processor cycle cost of the instruction |

## Verification
The hardest case to reach is proof that the test-and-modify instructions take Z from the byte as read and not from the byte they write back. The stimulus therefore picks memory and accumulator values where the two would give opposite Z: a byte with no bits in common with the mask, which becomes nonzero after the OR. A second case is a `start` held high with another opcode while an instruction is in flight. A third is a read-modify-write followed by a bit branch on the same byte, which shows that the write landed. The indexed bit-test forms are driven right at the page-zero wrap, across a page boundary and at the top of the address space.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int DW = 8;

    typedef enum logic [2:0] {
        K_NONE, K_MODBIT, K_BRBIT, K_TSET, K_TCLR, K_TEST
    } kind_e;

    typedef enum logic [2:0] {
        M_NONE, M_IMM, M_ZP, M_ZPX, M_ABS, M_ABSX
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ, ST_WAIT, ST_WRITE, ST_DONE
    } state_e;

    typedef struct packed {
        kind_e kind;
        mode_e mode;
        logic  rd;
        logic  wr;
    } dec_t;

    typedef struct packed {
        logic [DW-1:0] wdata;
        logic          z_we;
        logic          z;
        logic          nv_we;
        logic          n;
        logic          v;
        logic          taken;
        logic [2:0]    cyc;
    } res_t;

    function automatic dec_t decode_op(input logic [DW-1:0] op);
        dec_t d;
        d = '{kind: K_NONE, mode: M_NONE, rd: 1'b0, wr: 1'b0};
        if (op[3:0] == 4'h7) begin
            d = '{kind: K_MODBIT, mode: M_ZP, rd: 1'b1, wr: 1'b1};
        end else if (op[3:0] == 4'hF) begin
            d = '{kind: K_BRBIT, mode: M_ZP, rd: 1'b1, wr: 1'b0};
        end else begin
            case (op)
                8'h04: d = '{kind: K_TSET, mode: M_ZP,   rd: 1'b1, wr: 1'b1};
                8'h0C: d = '{kind: K_TSET, mode: M_ABS,  rd: 1'b1, wr: 1'b1};
                8'h14: d = '{kind: K_TCLR, mode: M_ZP,   rd: 1'b1, wr: 1'b1};
                8'h1C: d = '{kind: K_TCLR, mode: M_ABS,  rd: 1'b1, wr: 1'b1};
                8'h89: d = '{kind: K_TEST, mode: M_IMM,  rd: 1'b0, wr: 1'b0};
                8'h24: d = '{kind: K_TEST, mode: M_ZP,   rd: 1'b1, wr: 1'b0};
                8'h2C: d = '{kind: K_TEST, mode: M_ABS,  rd: 1'b1, wr: 1'b0};
                8'h34: d = '{kind: K_TEST, mode: M_ZPX,  rd: 1'b1, wr: 1'b0};
                8'h3C: d = '{kind: K_TEST, mode: M_ABSX, rd: 1'b1, wr: 1'b0};
                default: ;
            endcase
        end
        return d;
    endfunction

    function automatic logic [DW-1:0] bit_mask(input logic [2:0] idx);
        return DW'(1) << idx;
    endfunction

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
(
    input  logic [DW-1:0] op,
    output dec_t          dec
);
    always_comb dec = decode_op(op);
endmodule

// File: rtl/bitop_seq.sv
module bitop_seq
    import bitop_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   need_rd,
    input  logic   need_wr_q,
    output state_e state,
    output logic   accept
);
    assign accept = start && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (start) state <= need_rd ? ST_READ : ST_DONE;
                ST_READ:  state <= ST_WAIT;
                ST_WAIT:  state <= need_wr_q ? ST_WRITE : ST_DONE;
                ST_WRITE: state <= ST_DONE;
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bitop_eval.sv
module bitop_eval
    import bitop_pkg::*;
(
    input  kind_e         kind,
    input  mode_e         mode,
    input  logic [3:0]    op_top,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] data,
    output res_t          res
);
    logic [DW-1:0] mask;
    logic          hit;
    logic          no_overlap;

    assign mask       = bit_mask(op_top[2:0]);
    assign hit        = |(data & mask);
    assign no_overlap = (data & acc) == '0;

    always_comb begin
        res = '0;
        case (kind)
            K_MODBIT: begin
                res.wdata = op_top[3] ? (data | mask) : (data & ~mask);
                res.cyc   = 3'd5;
            end
            K_BRBIT: begin
                res.taken = (hit == op_top[3]);
                res.cyc   = res.taken ? 3'd3 : 3'd2;
            end
            K_TSET, K_TCLR: begin
                res.wdata = (kind == K_TSET) ? (data | acc) : (data & ~acc);
                res.z_we  = 1'b1;
                res.z     = no_overlap;
                res.cyc   = (mode == M_ABS) ? 3'd4 : 3'd3;
            end
            K_TEST: begin
                res.z_we = 1'b1;
                res.z    = no_overlap;
                if (mode != M_IMM) begin
                    res.nv_we = 1'b1;
                    res.n     = data[DW-1];
                    res.v     = data[DW-2];
                end
                case (mode)
                    M_IMM:   res.cyc = 3'd2;
                    M_ZP:    res.cyc = 3'd3;
                    default: res.cyc = 3'd4;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 16,
    parameter int CYC_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [7:0]        acc,
    input  logic [7:0]        x_idx,
    input  logic [7:0]        op_lo,
    input  logic [7:0]        op_hi,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              z_we,
    output logic              z_val,
    output logic              nv_we,
    output logic              n_val,
    output logic              v_val,
    output logic              br_taken,
    output logic [OFF_W-1:0]  br_offset,
    output logic [CYC_W-1:0]  cycles
);
    localparam int PAD_W = OFF_W - DW;

    dec_t          dec_in;
    state_e        state;
    logic          accept;
    kind_e         kind_q;
    mode_e         mode_q;
    logic          wr_q;
    logic [3:0]    optop_q;
    logic [DW-1:0] acc_q, x_q, lo_q, hi_q, data_q;
    logic [ADDR_W-1:0] ea;
    res_t          res;

    bitop_decode u_dec (.op(opcode), .dec(dec_in));

    bitop_seq u_seq (
        .clk(clk), .rst(rst), .start(start),
        .need_rd(dec_in.rd), .need_wr_q(wr_q),
        .state(state), .accept(accept)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= K_NONE;
            mode_q  <= M_NONE;
            wr_q    <= 1'b0;
            optop_q <= '0;
            acc_q   <= '0;
            x_q     <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            data_q  <= '0;
        end else if (accept) begin
            kind_q  <= dec_in.kind;
            mode_q  <= dec_in.mode;
            wr_q    <= dec_in.wr;
            optop_q <= opcode[7:4];
            acc_q   <= acc;
            x_q     <= x_idx;
            lo_q    <= op_lo;
            hi_q    <= op_hi;
            data_q  <= op_lo;
        end else if (state == ST_WAIT) begin
            data_q  <= mem_rdata;
        end
    end

    always_comb begin
        case (mode_q)
            M_ZPX:   ea = ADDR_W'(DW'(lo_q + x_q));
            M_ABS:   ea = ADDR_W'({hi_q, lo_q});
            M_ABSX:  ea = ADDR_W'({hi_q, lo_q}) + ADDR_W'(x_q);
            default: ea = ADDR_W'(lo_q);
        endcase
    end

    bitop_eval u_eval (
        .kind(kind_q), .mode(mode_q), .op_top(optop_q),
        .acc(acc_q), .data(data_q), .res(res)
    );

    assign mem_rd    = (state == ST_READ);
    assign mem_wr    = (state == ST_WRITE);
    assign mem_addr  = (mem_rd || mem_wr) ? ea : '0;
    assign mem_wdata = mem_wr ? res.wdata : '0;
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);

    assign z_we      = done && res.z_we;
    assign z_val     = done && res.z;
    assign nv_we     = done && res.nv_we;
    assign n_val     = done && res.n;
    assign v_val     = done && res.v;
    assign br_taken  = done && res.taken;
    assign br_offset = br_taken ? {{PAD_W{hi_q[DW-1]}}, hi_q} : '0;
    assign cycles    = done ? CYC_W'(res.cyc) : '0;
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 16,
    parameter int CYC_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              z_we,
    input logic              nv_we,
    input logic              br_taken,
    input logic [OFF_W-1:0]  br_offset,
    input logic [CYC_W-1:0]  cycles
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !mem_wr && !done && !z_we && !br_taken));

    p_wr_same_addr_r2: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_addr == $past(mem_addr, 2)));

    p_taken_cycles_r4: assert property (@(posedge clk) disable iff (rst)
        (done && br_taken) |-> (cycles == CYC_W'(3)));

    p_offset_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !br_taken |-> (br_offset == '0));

    p_nv_needs_z_r7: assert property (@(posedge clk) disable iff (rst)
        nv_we |-> z_we);

    p_wr_after_rd_r10: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(mem_rd, 2));

    p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
endmodule

bind bitop_unit bitop_unit_chk #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CYC_W(CYC_W)
) chk_i (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .z_we(z_we), .nv_we(nv_we), .br_taken(br_taken),
    .br_offset(br_offset), .cycles(cycles)
);

// File: tb/bitop_unit_tb_top.sv
`timescale 1ns/1ps
module bitop_unit_tb_top;
    localparam int ADDR_W = 16;
    localparam int OFF_W  = 16;
    localparam int CYC_W  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [7:0] opcode = 8'h00, acc = 8'h00, x_idx = 8'h00, op_lo = 8'h00, op_hi = 8'h00;
    logic [ADDR_W-1:0] mem_addr;
    logic mem_rd, mem_wr, busy, done, z_we, z_val, nv_we, n_val, v_val, br_taken;
    logic [7:0] mem_wdata;
    logic [7:0] rdata_q = 8'h00;
    logic [OFF_W-1:0] br_offset;
    logic [CYC_W-1:0] cycles;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] mem [0:65535];

    always #2.5 clk = ~clk;

    bitop_unit #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CYC_W(CYC_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .acc(acc),
        .x_idx(x_idx), .op_lo(op_lo), .op_hi(op_hi),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(rdata_q),
        .busy(busy), .done(done), .z_we(z_we), .z_val(z_val),
        .nv_we(nv_we), .n_val(n_val), .v_val(v_val),
        .br_taken(br_taken), .br_offset(br_offset), .cycles(cycles)
    );

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd) rdata_q <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        finish_run();
    end

    // behavioural reference: expectations from the requirements, cycle by cycle
    task automatic run_op(input string req, input logic [7:0] op, input logic [7:0] a,
                          input logic [7:0] xi, input logic [7:0] lo, input logic [7:0] hi,
                          input bit hold);
        int bitn, total, cyc;
        logic rd, wr, zw, zv, nvw, nv, vv, tk;
        logic [7:0] m, w;
        logic [15:0] ea, off;
        bitn = (op >> 4) & 7;
        rd = 0; wr = 0; zw = 0; zv = 0; nvw = 0; nv = 0; vv = 0; tk = 0;
        w = 0; off = 0; cyc = 0; ea = 0; m = lo;
        if ((op & 8'h0F) == 8'h07) begin
            rd = 1; wr = 1; ea = {8'h00, lo}; m = mem[ea];
            if (op[7]) w = m | (8'd1 << bitn); else w = m & ~(8'd1 << bitn);
            cyc = 5;
        end else if ((op & 8'h0F) == 8'h0F) begin
            rd = 1; ea = {8'h00, lo}; m = mem[ea];
            tk = (m[bitn] == op[7]);
            off = tk ? {{8{hi[7]}}, hi} : 16'h0000;
            cyc = tk ? 3 : 2;
        end else if (op == 8'h04 || op == 8'h0C || op == 8'h14 || op == 8'h1C) begin
            rd = 1; wr = 1;
            ea = op[3] ? {hi, lo} : {8'h00, lo};
            m = mem[ea];
            zw = 1; zv = ((m & a) == 8'h00);
            w = op[4] ? (m & ~a) : (m | a);
            cyc = op[3] ? 4 : 3;
        end else if (op == 8'h89) begin
            zw = 1; zv = ((lo & a) == 8'h00); cyc = 2;
        end else if (op == 8'h24 || op == 8'h2C || op == 8'h34 || op == 8'h3C) begin
            rd = 1;
            case (op)
                8'h24:   ea = {8'h00, lo};
                8'h2C:   ea = {hi, lo};
                8'h34:   ea = {8'h00, 8'(lo + xi)};
                default: ea = {hi, lo} + 16'(xi);
            endcase
            m = mem[ea];
            zw = 1; zv = ((m & a) == 8'h00); nvw = 1; nv = m[7]; vv = m[6];
            cyc = (op == 8'h24) ? 3 : 4;
        end
        total = !rd ? 1 : (wr ? 4 : 3);

        @(negedge clk);
        start = 1; opcode = op; acc = a; x_idx = xi; op_lo = lo; op_hi = hi;
        @(negedge clk);
        if (!hold) start = 0;
        for (int c = 1; c <= total; c++) begin
            if (c > 1) @(negedge clk);
            chk(req, "busy", 32'(busy), 32'(1));
            chk(req, "mem_rd", 32'(mem_rd), 32'(rd && c == 1));
            chk(req, "mem_wr", 32'(mem_wr), 32'(wr && c == 3));
            if (rd && c == 1) chk(req, "read addr", 32'(mem_addr), 32'(ea));
            if (wr && c == 3) begin
                chk(req, "write addr", 32'(mem_addr), 32'(ea));
                chk(req, "write data", 32'(mem_wdata), 32'(w));
            end
            chk(req, "done", 32'(done), 32'(c == total));
            if (c == total) begin
                chk(req, "z_we", 32'(z_we), 32'(zw));
                chk(req, "z_val", 32'(z_val), 32'(zv));
                chk(req, "nv_we", 32'(nv_we), 32'(nvw));
                chk(req, "n_val", 32'(n_val), 32'(nv));
                chk(req, "v_val", 32'(v_val), 32'(vv));
                chk(req, "br_taken", 32'(br_taken), 32'(tk));
                chk(req, "br_offset", 32'(br_offset), 32'(off));
                chk(req, "cycles", 32'(cycles), 32'(cyc));
            end
            if (hold && c == 1) begin start = 1; opcode = 8'h89; op_lo = 8'hFF; end
            if (hold && c == 2) start = 0;
        end
        @(negedge clk);
        chk(req, "busy after done", 32'(busy), 32'(0));
        chk(req, "done after done", 32'(done), 32'(0));
    endtask

    initial begin
        for (int i = 0; i < 65536; i++) mem[i] = 8'(i * 7 + (i >> 8) * 3 + 1);

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", 32'(busy), 32'(0));
        chk("R1", "done in reset", 32'(done), 32'(0));
        rst = 0;
        @(negedge clk);
        chk("R1", "busy idle", 32'(busy), 32'(0));
        chk("R1", "rd/wr idle", 32'({mem_rd, mem_wr}), 32'(0));
        chk("R1", "flags idle", 32'({z_we, nv_we, br_taken}), 32'(0));

        // R2: single-bit clear and set on zero page
        mem[16'h0040] = 8'hA5; run_op("R2", 8'h57, 8'h00, 8'h00, 8'h40, 8'h00, 0);
        mem[16'h0041] = 8'h00; run_op("R2", 8'hB7, 8'h00, 8'h00, 8'h41, 8'h00, 0);
        mem[16'h0042] = 8'h01; run_op("R2", 8'hF7, 8'h00, 8'h00, 8'h42, 8'h00, 0);
        mem[16'h0043] = 8'hFF; run_op("R2", 8'h07, 8'h00, 8'h00, 8'h43, 8'h00, 0);
        // R2 R3: write landed, bit 5 of 0x40 now clear so the reset-branch is taken
        run_op("R2 R3", 8'h5F, 8'h00, 8'h00, 8'h40, 8'h22, 0);

        // R3 R4: bit branches
        mem[16'h0044] = 8'h80; run_op("R3 R4", 8'hFF, 8'h00, 8'h00, 8'h44, 8'h80, 0);
        mem[16'h0045] = 8'hFB; run_op("R3 R4", 8'h2F, 8'h00, 8'h00, 8'h45, 8'h10, 0);
        mem[16'h0046] = 8'h01; run_op("R3", 8'h0F, 8'h00, 8'h00, 8'h46, 8'h7F, 0);
        mem[16'h0047] = 8'h00; run_op("R3 R4", 8'hCF, 8'h00, 8'h00, 8'h47, 8'hF0, 0);

        // R5 R6 R7: Z taken from the byte before modification
        mem[16'h0050] = 8'hF0; run_op("R5 R7", 8'h04, 8'h0F, 8'h00, 8'h50, 8'h00, 0);
        mem[16'h1234] = 8'h01; run_op("R5 R7", 8'h0C, 8'h81, 8'h00, 8'h34, 8'h12, 0);
        mem[16'h0051] = 8'h3C; run_op("R6 R7", 8'h14, 8'h0F, 8'h00, 8'h51, 8'h00, 0);
        mem[16'h2345] = 8'h7F; run_op("R6 R7", 8'h1C, 8'h80, 8'h00, 8'h45, 8'h23, 0);

        // R8: immediate bit test
        run_op("R8", 8'h89, 8'h3F, 8'h00, 8'hC0, 8'h00, 0);
        run_op("R8", 8'h89, 8'h41, 8'h00, 8'h01, 8'h00, 0);

        // R9: memory bit-test forms and index wrap
        mem[16'h0060] = 8'hC1; run_op("R9", 8'h24, 8'h01, 8'h00, 8'h60, 8'h00, 0);
        mem[16'h3456] = 8'h40; run_op("R9", 8'h2C, 8'h80, 8'h00, 8'h56, 8'h34, 0);
        mem[16'h0010] = 8'h80; run_op("R9", 8'h34, 8'h80, 8'h20, 8'hF0, 8'h00, 0);
        mem[16'h1300] = 8'h3F; run_op("R9", 8'h3C, 8'hC0, 8'h01, 8'hFF, 8'h12, 0);
        mem[16'h0000] = 8'hE0; run_op("R9", 8'h3C, 8'h20, 8'h01, 8'hFF, 8'hFF, 0);

        // R11: unsupported opcode
        run_op("R11", 8'hEA, 8'hFF, 8'h00, 8'h00, 8'h00, 0);

        // R10: start held high with another opcode while busy is ignored
        mem[16'h0052] = 8'h00; run_op("R10", 8'h04, 8'h0C, 8'h00, 8'h52, 8'h00, 1);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule